// File: doc/BRIEF.md
# Focus Search and Capture Sequencer

This block brings an optical pickup lens into focus. While the servo loop is open it produces a triangular search code for the focus drive DAC. The code climbs from a programmable low limit to a high limit and falls back again, in steps of a programmable size, one step per tick enable. A rising code means the lens is moving toward the disc. The sequencer watches the focus-OK level and the focus zero-cross comparator bit. It closes the loop at the first point where all three closing conditions are met at once, and then freezes the search code.

After the loop closes, a blanking timer counts a programmable number of ticks. During that time focus-OK is not examined. After the timer ends the block supervises focus-OK. A low level ends the capture and raises a sticky focus-lost flag, which protection firmware can act on. If the ramp completes a programmable number of full sweeps without closing, the block returns to idle and raises a sticky search-fail flag. An abort command returns to idle from any state.

Top module: `focus_acq_seq`

## Requirements
- R1: During reset the outputs are: search code 0, direction near (1), close strobe 0, closed indicator high (1), focus-lost 0, search-fail 0.
- R2: A start pulse in idle loads the low limit into the search code, sets the direction to near (1), clears both flags and begins searching. A start pulse in any other state has no effect on the code.
- R3: While searching, each tick moves the code by one step in the current direction. An upward step that reaches or passes the high limit clamps to it and sets the direction to far (0). A downward step that reaches or passes the low limit clamps to it and sets the direction to near (1). Without a tick or a start, the code does not change.
- R4: The loop closes only in a cycle where all of these hold: the block is searching, the direction is near, focus-OK is 1, and the zero-cross bit is 1 after being 0 at the previous clock edge. If any of them is missing, the loop stays open.
- R5: On closure the close strobe is high for exactly one cycle, and the closed indicator falls from 1 to 0 at the same edge. While the indicator is 0, the code and the direction are frozen.
- R6: After closure, focus-OK is ignored until the blanking timer has counted its programmed number of ticks.
- R7: After blanking, a focus-OK of 0 sets focus-lost, raises the closed indicator to 1 and returns to idle. Focus-lost then stays set until the next accepted start.
- R8: When the code returns to the low limit and this completes the programmed number of full sweeps without closure, search-fail is set, the closed indicator stays 1 and the block idles with the code at the low limit. Search-fail stays set until the next accepted start.
- R9: An abort returns to idle from any state. It raises the closed indicator to 1, produces no close strobe and sets neither flag. After that, ticks and focus-OK do not move the code or set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Step and timer enable |
| start | input | 1 | Begin a search (accepted in idle) |
| abort | input | 1 | Return to idle from any state |
| rfok | input | 1 | Focus-OK level |
| fzc | input | 1 | Focus zero-cross comparator bit |
| min_code | input | CODE_W | Low limit of the search code |
| max_code | input | CODE_W | High limit of the search code |
| step_size | input | CODE_W | Code change per tick |
| max_sweeps | input | SWEEP_W | Full sweeps allowed before failing |
| settle_len | input | TIMER_W | Blanking length in ticks |
| dac_code | output | CODE_W | Search DAC code |
| dir_near | output | 1 | 1 while the ramp moves toward the disc |
| close_pulse | output | 1 | One-cycle strobe on loop closure |
| closed_n | output | 1 | Low while the loop is closed |
| focus_lost | output | 1 | Sticky focus-loss flag |
| search_fail | output | 1 | Sticky search-failure flag |

## Verification
Some properties are checked on every cycle: the close strobe lasts one cycle, the closed indicator falls at the same edge as the strobe, and each closure follows a cycle in which focus-OK, the near direction and a fresh zero-cross rise were all present. Every cycle also confirms that the code stays frozen while closed or when no tick and no start arrive, that abort always reopens the loop, and that each flag rises only with the loop open. The bench scenarios cover what a single-cycle property cannot show. These are the clamp points at both limits, closure attempts with one condition missing, and focus-OK being ignored across the whole blanking window. They also cover failure after exactly the programmed number of sweeps and the flags clearing only on the next accepted start.

// File: rtl/focus_pkg.sv
package focus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_SETTLE = 2'd2,
        ST_TRACK  = 2'd3
    } fstate_e;
endpackage

// File: rtl/focus_ramp.sv
// Next-step arithmetic of the triangular search ramp (combinational).
module focus_ramp #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code,
    input  logic              dir_near,
    input  logic [CODE_W-1:0] lo,
    input  logic [CODE_W-1:0] hi,
    input  logic [CODE_W-1:0] step,
    output logic [CODE_W-1:0] nxt_code,
    output logic              nxt_dir,
    output logic              wrap
);
    localparam int SUM_W = CODE_W + 1;

    logic [SUM_W-1:0]  up_sum;
    logic [CODE_W-1:0] above_lo;

    assign up_sum   = {1'b0, code} + {1'b0, step};
    assign above_lo = code - lo;

    always_comb begin
        nxt_code = code;
        nxt_dir  = dir_near;
        wrap     = 1'b0;
        if (dir_near) begin
            if (up_sum >= {1'b0, hi}) begin
                nxt_code = hi;
                nxt_dir  = 1'b0;
            end else begin
                nxt_code = up_sum[CODE_W-1:0];
            end
        end else begin
            if (above_lo <= step) begin
                nxt_code = lo;
                nxt_dir  = 1'b1;
                wrap     = 1'b1;
            end else begin
                nxt_code = code - step;
            end
        end
    end
endmodule

// File: rtl/fzc_edge.sv
// Detects the re-arming rise of the zero-cross comparator bit.
module fzc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fzc,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = fzc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign rise = fzc & ~prev_q;
endmodule

// File: rtl/settle_timer.sv
// Counts tick enables while not cleared; done in the cycle the count reaches len.
module settle_timer #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic [TIMER_W-1:0] len,
    output logic               done
);
    localparam int CNT_W = TIMER_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + 1'b1;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)     cnt_d = '0;
        else if (en && cnt_q < {1'b0, len}) cnt_d = cnt_inc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = !clr && en && (cnt_inc >= {1'b0, len});
endmodule

// File: rtl/focus_acq_seq.sv
module focus_acq_seq
    import focus_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int SWEEP_W = 8,
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               start,
    input  logic               abort,
    input  logic               rfok,
    input  logic               fzc,
    input  logic [CODE_W-1:0]  min_code,
    input  logic [CODE_W-1:0]  max_code,
    input  logic [CODE_W-1:0]  step_size,
    input  logic [SWEEP_W-1:0] max_sweeps,
    input  logic [TIMER_W-1:0] settle_len,
    output logic [CODE_W-1:0]  dac_code,
    output logic               dir_near,
    output logic               close_pulse,
    output logic               closed_n,
    output logic               focus_lost,
    output logic               search_fail
);
    localparam int SWC_W = SWEEP_W + 1;

    typedef struct packed {
        fstate_e            state;
        logic [CODE_W-1:0]  code;
        logic               dir;
        logic               pulse;
        logic               closed_n;
        logic               lost;
        logic               fail;
        logic [SWEEP_W-1:0] sweeps;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [CODE_W-1:0] ramp_code;
    logic              ramp_dir;
    logic              ramp_wrap;
    logic              zc_rise;
    logic              blank_done;
    logic [SWC_W-1:0]  sweeps_inc;

    assign sweeps_inc = {1'b0, seq_q.sweeps} + 1'b1;

    focus_ramp #(.CODE_W(CODE_W)) u_ramp (
        .code     (seq_q.code),
        .dir_near (seq_q.dir),
        .lo       (min_code),
        .hi       (max_code),
        .step     (step_size),
        .nxt_code (ramp_code),
        .nxt_dir  (ramp_dir),
        .wrap     (ramp_wrap)
    );

    fzc_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .fzc   (fzc),
        .rise  (zc_rise)
    );

    settle_timer #(.TIMER_W(TIMER_W)) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (seq_q.state != ST_SETTLE),
        .en    (tick),
        .len   (settle_len),
        .done  (blank_done)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.pulse = 1'b0;
        if (abort) begin
            seq_d.state    = ST_IDLE;
            seq_d.closed_n = 1'b1;
        end else begin
            unique case (seq_q.state)
                ST_IDLE: begin
                    if (start) begin
                        seq_d.state  = ST_SEARCH;
                        seq_d.code   = min_code;
                        seq_d.dir    = 1'b1;
                        seq_d.sweeps = '0;
                        seq_d.lost   = 1'b0;
                        seq_d.fail   = 1'b0;
                    end
                end
                ST_SEARCH: begin
                    if (seq_q.dir && rfok && zc_rise) begin
                        seq_d.state    = ST_SETTLE;
                        seq_d.pulse    = 1'b1;
                        seq_d.closed_n = 1'b0;
                    end else if (tick) begin
                        seq_d.code = ramp_code;
                        seq_d.dir  = ramp_dir;
                        if (ramp_wrap) begin
                            if (sweeps_inc >= {1'b0, max_sweeps}) begin
                                seq_d.state = ST_IDLE;
                                seq_d.fail  = 1'b1;
                            end else begin
                                seq_d.sweeps = sweeps_inc[SWEEP_W-1:0];
                            end
                        end
                    end
                end
                ST_SETTLE: begin
                    if (blank_done) seq_d.state = ST_TRACK;
                end
                ST_TRACK: begin
                    if (!rfok) begin
                        seq_d.state    = ST_IDLE;
                        seq_d.lost     = 1'b1;
                        seq_d.closed_n = 1'b1;
                    end
                end
                default: seq_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state    <= ST_IDLE;
            seq_q.code     <= '0;
            seq_q.dir      <= 1'b1;
            seq_q.pulse    <= 1'b0;
            seq_q.closed_n <= 1'b1;
            seq_q.lost     <= 1'b0;
            seq_q.fail     <= 1'b0;
            seq_q.sweeps   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign dac_code    = seq_q.code;
    assign dir_near    = seq_q.dir;
    assign close_pulse = seq_q.pulse;
    assign closed_n    = seq_q.closed_n;
    assign focus_lost  = seq_q.lost;
    assign search_fail = seq_q.fail;
endmodule

// File: rtl/focus_acq_seq_chk.sv
module focus_acq_seq_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              start,
    input logic              abort,
    input logic              rfok,
    input logic              fzc,
    input logic [CODE_W-1:0] min_code,
    input logic [CODE_W-1:0] dac_code,
    input logic              dir_near,
    input logic              close_pulse,
    input logic              closed_n,
    input logic              focus_lost,
    input logic              search_fail
);
    assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> $stable(dac_code));

    assert_close_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
        close_pulse |-> ($past(rfok) && $past(dir_near) && $past(fzc) && !$past(fzc, 2)));

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        close_pulse |=> !close_pulse);

    assert_close_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        close_pulse |-> (!closed_n && $past(closed_n)));

    assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !closed_n |-> ($stable(dac_code) && $stable(dir_near)));

    assert_lost_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(focus_lost) |-> (closed_n && !$past(rfok)));

    assert_fail_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(search_fail) |-> (closed_n && dac_code == min_code));

    assert_abort_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (closed_n && !close_pulse));
endmodule

bind focus_acq_seq focus_acq_seq_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .start       (start),
    .abort       (abort),
    .rfok        (rfok),
    .fzc         (fzc),
    .min_code    (min_code),
    .dac_code    (dac_code),
    .dir_near    (dir_near),
    .close_pulse (close_pulse),
    .closed_n    (closed_n),
    .focus_lost  (focus_lost),
    .search_fail (search_fail)
);

// File: tb/sim_focus_acq_seq.sv
`timescale 1ns/1ps
module sim_focus_acq_seq;
    localparam int CW = 8;
    localparam int SW = 8;
    localparam int TW = 16;
    localparam logic [1:0] EV_CLOSE = 2'd1;
    localparam logic [1:0] EV_LOST  = 2'd2;
    localparam logic [1:0] EV_FAIL  = 2'd3;

    typedef struct packed {
        logic [1:0]    kind;
        logic [CW-1:0] code;
    } ev_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, start = 1'b0, abort = 1'b0, rfok = 1'b0, fzc = 1'b0;
    logic [CW-1:0] min_code = 8'd16, max_code = 8'd64, step_size = 8'd16;
    logic [SW-1:0] max_sweeps = 8'd3;
    logic [TW-1:0] settle_len = 16'd4;
    logic [CW-1:0] dac_code;
    logic dir_near, close_pulse, closed_n, focus_lost, search_fail;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    ev_t exp_q[$];

    always #2 clk = ~clk;

    focus_acq_seq #(.CODE_W(CW), .SWEEP_W(SW), .TIMER_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .abort(abort),
        .rfok(rfok), .fzc(fzc), .min_code(min_code), .max_code(max_code),
        .step_size(step_size), .max_sweeps(max_sweeps), .settle_len(settle_len),
        .dac_code(dac_code), .dir_near(dir_near), .close_pulse(close_pulse),
        .closed_n(closed_n), .focus_lost(focus_lost), .search_fail(search_fail)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [1:0] kind, input logic [CW-1:0] code);
        exp_q.push_back('{kind: kind, code: code});
    endtask

    // Monitor: pops one expected item per observed event.
    logic lost_prev = 1'b0, fail_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (close_pulse)               mon_event(EV_CLOSE);
            if (focus_lost && !lost_prev)  mon_event(EV_LOST);
            if (search_fail && !fail_prev) mon_event(EV_FAIL);
        end
        lost_prev <= focus_lost;
        fail_prev <= search_fail;
    end

    task automatic mon_event(input logic [1:0] kind);
        ev_t e;
        if (exp_q.size() == 0) begin
            chk("R5/R7/R8 unexpected event kind", int'(kind), 0);
        end else begin
            e = exp_q.pop_front();
            chk("R5/R7/R8 event kind", int'(kind), int'(e.kind));
            chk("R5/R7/R8 event code", int'(dac_code), int'(e.code));
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cycle();
        // R1 reset values
        chk("R1 code", dac_code, 0);
        chk("R1 dir", dir_near, 1);
        chk("R1 pulse", close_pulse, 0);
        chk("R1 closed_n", closed_n, 1);
        chk("R1 lost", focus_lost, 0);
        chk("R1 fail", search_fail, 0);
        rst_n = 1'b1;
        cycle();
        chk("R3 no tick idle", dac_code, 0);

        start = 1'b1; cycle(); start = 1'b0;
        chk("R2 start code", dac_code, 16);
        chk("R2 start dir", dir_near, 1);
        chk("R2 start closed_n", closed_n, 1);

        tick = 1'b1;
        cycle(); chk("R3 up 32", dac_code, 32);
        cycle(); chk("R3 up 48", dac_code, 48);
        cycle(); chk("R3 clamp hi", dac_code, 64);
        chk("R3 dir far at hi", dir_near, 0);
        tick = 1'b0;
        start = 1'b1; cycle(); start = 1'b0;
        chk("R2 start ignored busy", dac_code, 64);
        tick = 1'b1; cycle(); tick = 1'b0;
        chk("R3 down 48", dac_code, 48);

        // R4: far direction rejects closure
        rfok = 1'b1; fzc = 1'b0; cycle();
        fzc = 1'b1; cycle();
        chk("R4 far no close", closed_n, 1);
        tick = 1'b1;
        cycle(); chk("R3 down 32", dac_code, 32);
        cycle(); chk("R3 clamp lo", dac_code, 16);
        chk("R3 dir near at lo", dir_near, 1);
        tick = 1'b0;
        cycle();
        chk("R4 no edge no close", closed_n, 1);
        rfok = 1'b0; fzc = 1'b0; cycle();
        fzc = 1'b1; cycle();
        chk("R4 rfok low no close", closed_n, 1);
        tick = 1'b1; cycle(); tick = 1'b0;
        chk("R3 up again 32", dac_code, 32);

        // Closure
        fzc = 1'b0; cycle();
        push(EV_CLOSE, 8'd32);
        rfok = 1'b1; fzc = 1'b1; cycle();
        chk("R4 close pulse", close_pulse, 1);
        chk("R5 closed_n low", closed_n, 0);
        fzc = 1'b0; cycle();
        chk("R5 pulse single", close_pulse, 0);

        // Blanking
        rfok = 1'b0; tick = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cycle();
            chk("R6 blank lost", focus_lost, 0);
            chk("R6 blank closed_n", closed_n, 0);
            chk("R5 frozen code", dac_code, 32);
        end
        rfok = 1'b1; cycle(); tick = 1'b0;
        chk("R6 blank end closed_n", closed_n, 0);
        cycle();
        chk("R6 track closed_n", closed_n, 0);
        push(EV_LOST, 8'd32);
        rfok = 1'b0; cycle();
        chk("R7 lost set", focus_lost, 1);
        chk("R7 closed_n high", closed_n, 1);
        cycle();
        chk("R7 lost held", focus_lost, 1);
        start = 1'b1; cycle(); start = 1'b0;
        chk("R7 lost cleared by start", focus_lost, 0);
        chk("R2 restart code", dac_code, 16);

        // Search failure after 3 sweeps (18 ticks)
        tick = 1'b1;
        repeat (17) cycle();
        chk("R8 fail not yet", search_fail, 0);
        chk("R3 code tick 17", dac_code, 32);
        push(EV_FAIL, 8'd16);
        cycle();
        chk("R8 fail set", search_fail, 1);
        chk("R8 fail code", dac_code, 16);
        chk("R8 fail closed_n", closed_n, 1);
        cycle(); cycle();
        chk("R8 idle no ramp", dac_code, 16);
        chk("R8 fail held", search_fail, 1);
        tick = 1'b0;

        // Abort during search
        start = 1'b1; cycle(); start = 1'b0;
        chk("R8 fail cleared by start", search_fail, 0);
        tick = 1'b1; cycle(); cycle(); tick = 1'b0;
        chk("R3 up 48 again", dac_code, 48);
        abort = 1'b1; cycle(); abort = 1'b0;
        chk("R9 abort closed_n", closed_n, 1);
        tick = 1'b1; cycle(); tick = 1'b0;
        chk("R9 idle after abort", dac_code, 48);

        // Abort during blanking
        start = 1'b1; cycle(); start = 1'b0;
        tick = 1'b1; cycle(); tick = 1'b0;
        fzc = 1'b0; cycle();
        push(EV_CLOSE, 8'd32);
        rfok = 1'b1; fzc = 1'b1; cycle();
        chk("R5 second close", closed_n, 0);
        abort = 1'b1; cycle(); abort = 1'b0;
        chk("R9 abort reopens", closed_n, 1);
        chk("R9 abort no lost", focus_lost, 0);
        rfok = 1'b0; tick = 1'b1;
        repeat (6) cycle();
        tick = 1'b0;
        chk("R9 no lost after abort", focus_lost, 0);
        chk("R9 code frozen idle", dac_code, 32);

        cycle();
        chk("R5/R7/R8 pending events", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule